// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Clear-to-Send Gating

This block turns words held in a four-entry first-in-first-out queue into asynchronous serial frames. Each frame has a low start bit, then 8 or 9 data bits with the least significant bit first, then an optional parity bit when the data is 8 bits wide, and finally one or two high stop bits. Every bit lasts 16 pulses of an external baud enable (`baud_tick`). The block samples the framing settings when a frame begins, so a change only affects later frames.

When flow control is enabled, an active-low clear-to-send input stops new frames from starting. A frame that has already started always runs to its end. A one-cycle request queues a break: the line goes low for 13 bit times and then returns high for one stop bit. When the line is idle, a pending break starts before any queued data word. The interrupt output stays high while the queue has a free entry. A loopback switch sends the serial stream to a separate output and holds the external line idle.

The controller is a state machine with states IDLE, START, DATA, PARITY, STOP and BREAK. Its transitions are:
- IDLE→BREAK when a break is pending and sending is permitted.
- IDLE→START when the queue holds a word and sending is permitted.
- START→DATA at the end of the start bit.
- DATA→PARITY after the last data bit when parity is active.
- DATA→STOP after the last data bit when parity is off.
- PARITY→STOP at the end of the parity bit.
- STOP→IDLE after the last stop bit.
- BREAK→STOP after the 13th low bit time.

Top module: `serial_tx_engine`

## Requirements
- R1: After reset `txd` and `loop_out` are high and `tx_irq` is high. The line is high whenever no frame is in progress.
- R2: In 8-bit mode (`nine_bit`=0) a frame is one low start bit followed by 8 data bits, least significant bit first. Each bit lasts 16 `baud_tick` pulses.
- R3: With `nine_bit`=1 the frame carries `wr_data[8:0]`, least significant bit first, and never has a parity bit, whatever `par_sel` holds.
- R4: `par_sel` encoding: 2'b01 is even, 2'b10 is odd, 2'b00 and 2'b11 are none. In 8-bit mode with even or odd selected, one parity bit follows the data. It makes the count of ones in data plus parity even or odd.
- R5: `two_stop`=1 gives two high stop bits and `two_stop`=0 gives one.
- R6: Words leave in the order they were written. The queue holds 4 words. A write made while `tx_irq` is low is dropped.
- R7: `tx_irq` is high exactly while the queue holds fewer than 4 words.
- R8: With `flow_en`=1 and `cts_n`=1, no new frame or break starts. With `flow_en`=0, `cts_n` has no effect.
- R9: A frame that has started completes even if `cts_n` rises during it.
- R10: A one-cycle `break_req` produces a low line for 13 bit times (208 ticks), followed by one high stop bit. A break pending at launch goes before queued data.
- R11: With `loop_en`=1, `txd` stays high and `loop_out` carries the serial stream. With `loop_en`=0, `loop_out` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_tick | input | 1 | Enable at 16x the bit rate |
| wr_en | input | 1 | Write strobe for the queue |
| wr_data | input | 9 | Word to send (bit 8 used only in 9-bit mode) |
| nine_bit | input | 1 | Selects 9 data bits |
| par_sel | input | 2 | Parity select: 01 even, 10 odd, else none |
| two_stop | input | 1 | Selects two stop bits |
| flow_en | input | 1 | Enables clear-to-send gating |
| cts_n | input | 1 | Clear to send, active low |
| break_req | input | 1 | One-cycle request for a break |
| loop_en | input | 1 | Routes the stream to loop_out |
| txd | output | 1 | Serial line |
| loop_out | output | 1 | Loopback copy of the stream |
| tx_irq | output | 1 | High while the queue has room |

## Verification
A write to the queue and the launch of a frame, which pops the queue, can happen in the same clock edge. The write is accepted if the queue was not full before that edge, and the pop does not free room for it in that cycle. The bench provokes the overlap by writing bursts at random gaps while frames are being sent, so some writes land on a full queue at the moment a frame starts. It decides whether each write was accepted from `tx_irq` just before the edge. It then matches the decoded frames against that expected order, and any dropped or duplicated word shows up as a miscompare.

// File: rtl/sertx_pkg.sv
`timescale 1ns/1ps
package sertx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP,
        ST_BREAK
    } tx_state_e;

    typedef enum logic [1:0] {
        PAR_OFF  = 2'b00,
        PAR_EVEN = 2'b01,
        PAR_ODD  = 2'b10,
        PAR_OFF2 = 2'b11
    } par_mode_e;

endpackage

// File: rtl/sertx_queue.sv
`timescale 1ns/1ps
module sertx_queue #(
    parameter int W     = 9,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_req,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] pop_data,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] LVL_FULL = CW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic [CW-1:0] level;
    logic          push;

    // Acceptance depends only on the level before the edge
    assign push     = push_req && !full;
    assign full     = (level == LVL_FULL);
    assign empty    = (level == '0);
    assign pop_data = mem[rptr];

    always_ff @(posedge clk) begin
        if (push) mem[wptr] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            level <= '0;
        end else begin
            if (push) wptr <= (wptr == PTR_LAST) ? '0 : wptr + 1'b1;
            if (pop)  rptr <= (rptr == PTR_LAST) ? '0 : rptr + 1'b1;
            unique case ({push, pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    // R6: a write on a full queue is dropped
    a_r6_drop_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push_req && !pop) |=> full);

    // R6: the framer never pops an empty queue
    a_r6_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

endmodule

// File: rtl/sertx_framer.sv
`timescale 1ns/1ps
module sertx_framer
    import sertx_pkg::*;
#(
    parameter int W        = 9,
    parameter int TPB      = 16,
    parameter int BRK_BITS = 13
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         q_empty,
    input  logic [W-1:0] q_data,
    input  logic         nine_bit,
    input  logic [1:0]   par_sel,
    input  logic         two_stop,
    input  logic         flow_en,
    input  logic         cts_n,
    input  logic         break_req,
    output logic         q_pop,
    output logic         line
);
    localparam int TCW  = $clog2(TPB);
    localparam int BMAX = (BRK_BITS > W) ? BRK_BITS : W;
    localparam int BCW  = $clog2(BMAX + 1);
    localparam logic [TCW-1:0] TC_LAST    = TCW'(TPB - 1);
    localparam logic [BCW-1:0] BRK_LAST   = BCW'(BRK_BITS - 1);
    localparam logic [BCW-1:0] LAST_WIDE  = BCW'(W - 1);
    localparam logic [BCW-1:0] LAST_NARROW = BCW'(W - 2);

    tx_state_e      state, state_nxt;
    logic [TCW-1:0] tcnt;
    logic [BCW-1:0] bcnt;
    logic [W-1:0]   shreg;
    logic           nine_q, two_q, par_on_q, par_bit_q, brk_pend;
    logic           go, launch_brk, launch_data, bit_end;
    logic [BCW-1:0] data_last;

    assign go          = !flow_en || !cts_n;
    assign launch_brk  = (state == ST_IDLE) && brk_pend && go;
    assign launch_data = (state == ST_IDLE) && !brk_pend && !q_empty && go;
    assign bit_end     = tick && (tcnt == TC_LAST);
    assign data_last   = nine_q ? LAST_WIDE : LAST_NARROW;
    assign q_pop       = launch_data;

    // next-state decode
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:   if (launch_brk) state_nxt = ST_BREAK;
                       else if (launch_data) state_nxt = ST_START;
            ST_START:  if (bit_end) state_nxt = ST_DATA;
            ST_DATA:   if (bit_end && bcnt == data_last)
                           state_nxt = par_on_q ? ST_PARITY : ST_STOP;
            ST_PARITY: if (bit_end) state_nxt = ST_STOP;
            ST_STOP:   if (bit_end && bcnt == BCW'(two_q)) state_nxt = ST_IDLE;
            ST_BREAK:  if (bit_end && bcnt == BRK_LAST) state_nxt = ST_STOP;
            default:   state_nxt = ST_IDLE;
        endcase
    end

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            tcnt      <= '0;
            bcnt      <= '0;
            shreg     <= '0;
            nine_q    <= 1'b0;
            two_q     <= 1'b0;
            par_on_q  <= 1'b0;
            par_bit_q <= 1'b0;
            brk_pend  <= 1'b0;
        end else begin
            state    <= state_nxt;
            brk_pend <= break_req || (brk_pend && !launch_brk);
            if (state_nxt != state) begin
                tcnt <= '0;
                bcnt <= '0;
            end else if (tick) begin
                tcnt <= bit_end ? '0 : tcnt + 1'b1;
                if (bit_end) bcnt <= bcnt + 1'b1;
            end
            if (launch_data) begin
                shreg     <= q_data;
                nine_q    <= nine_bit;
                two_q     <= two_stop;
                par_on_q  <= !nine_bit &&
                             (par_sel == PAR_EVEN || par_sel == PAR_ODD);
                par_bit_q <= (^q_data[W-2:0]) ^ (par_sel == PAR_ODD);
            end else if (launch_brk) begin
                two_q    <= 1'b0;
                par_on_q <= 1'b0;
            end else if (state == ST_DATA && bit_end) begin
                shreg <= shreg >> 1;
            end
        end
    end

    // line level from state
    always_comb begin
        unique case (state)
            ST_IDLE:   line = 1'b1;
            ST_START:  line = 1'b0;
            ST_DATA:   line = shreg[0];
            ST_PARITY: line = par_bit_q;
            ST_STOP:   line = 1'b1;
            ST_BREAK:  line = 1'b0;
            default:   line = 1'b1;
        endcase
    end

    // R1: the line rests high between frames
    a_r1_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> line);

    // R8: clear-to-send deasserted keeps the controller idle
    a_r8_cts_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && flow_en && cts_n) |=> (state == ST_IDLE));

    // R9: only the stop state may return to idle
    a_r9_no_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && state != ST_STOP) |=> (state != ST_IDLE));

    // R3: parity is never sent after nine data bits
    a_r3_no_parity_wide: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PARITY) |-> !nine_q);

    // R10: a break always ends through a stop bit
    a_r10_break_to_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BREAK) |=> (state == ST_BREAK || state == ST_STOP));

endmodule

// File: rtl/serial_tx_engine.sv
`timescale 1ns/1ps
module serial_tx_engine #(
    parameter int WORD_W        = 9,
    parameter int DEPTH         = 4,
    parameter int TICKS_PER_BIT = 16,
    parameter int BREAK_BITS    = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              nine_bit,
    input  logic [1:0]        par_sel,
    input  logic              two_stop,
    input  logic              flow_en,
    input  logic              cts_n,
    input  logic              break_req,
    input  logic              loop_en,
    output logic              txd,
    output logic              loop_out,
    output logic              tx_irq
);
    logic              q_pop, q_empty, q_full, line;
    logic [WORD_W-1:0] q_data;

    sertx_queue #(.W(WORD_W), .DEPTH(DEPTH)) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_req  (wr_en),
        .push_data (wr_data),
        .pop       (q_pop),
        .pop_data  (q_data),
        .empty     (q_empty),
        .full      (q_full)
    );

    sertx_framer #(.W(WORD_W), .TPB(TICKS_PER_BIT), .BRK_BITS(BREAK_BITS)) u_framer (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (baud_tick),
        .q_empty   (q_empty),
        .q_data    (q_data),
        .nine_bit  (nine_bit),
        .par_sel   (par_sel),
        .two_stop  (two_stop),
        .flow_en   (flow_en),
        .cts_n     (cts_n),
        .break_req (break_req),
        .q_pop     (q_pop),
        .line      (line)
    );

    assign txd      = loop_en ? 1'b1 : line;
    assign loop_out = loop_en ? line : 1'b1;
    assign tx_irq   = !q_full;

    // R7: room can only vanish right after a write
    a_r7_irq_falls_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_irq) |-> $past(wr_en));

    // R7: room only reappears when a frame takes a word
    a_r7_irq_rises_on_launch: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_irq) |-> $past(q_pop));

endmodule

// File: tb/serial_tx_engine_bench.sv
`timescale 1ns/1ps
module serial_tx_engine_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [8:0] wr_data = '0;
    logic       nine_bit = 1'b0;
    logic [1:0] par_sel = 2'b00;
    logic       two_stop = 1'b0;
    logic       flow_en = 1'b0;
    logic       cts_n = 1'b0;
    logic       break_req = 1'b0;
    logic       loop_en = 1'b0;
    logic       txd, loop_out, tx_irq;

    int n_chk = 0;
    int n_bad = 0;
    int loop_bad = 0;
    bit mon_en = 1'b0;
    logic [8:0] expq[$];

    serial_tx_engine u_serial_tx_engine (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .wr_en(wr_en),
        .wr_data(wr_data), .nine_bit(nine_bit), .par_sel(par_sel),
        .two_stop(two_stop), .flow_en(flow_en), .cts_n(cts_n),
        .break_req(break_req), .loop_en(loop_en), .txd(txd),
        .loop_out(loop_out), .tx_irq(tx_irq)
    );

    always #10 clk = ~clk;

    // baud enable: one pulse every 4 clocks
    int tdiv = 0;
    always @(negedge clk) begin
        tdiv      <= (tdiv == 3) ? 0 : tdiv + 1;
        baud_tick <= (tdiv == 2);
    end

    logic mon_line;
    assign mon_line = loop_en ? loop_out : txd;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit exp_par(input logic [8:0] d, input logic [1:0] mode);
        return (^d[7:0]) ^ (mode == 2'b10);
    endfunction

    // loopback quiet-line watcher (R11)
    always @(negedge clk) begin
        if (rst_n) begin
            if (loop_en && txd !== 1'b1) loop_bad++;
            if (!loop_en && loop_out !== 1'b1) loop_bad++;
        end
    end

    // frame decoder
    initial begin
        forever begin
            @(negedge clk);
            if (mon_en && mon_line === 1'b0) begin
                int nb;
                bit has_par;
                logic [8:0] d;
                nb = nine_bit ? 9 : 8;
                has_par = !nine_bit && (par_sel == 2'b01 || par_sel == 2'b10);
                d = '0;
                repeat (30) @(negedge clk);
                chk(mon_line == 1'b0, "R2 start bit", int'(mon_line), 0);
                for (int i = 0; i < nb; i++) begin
                    repeat (64) @(negedge clk);
                    d[i] = mon_line;
                end
                if (has_par) begin
                    repeat (64) @(negedge clk);
                    chk(mon_line == exp_par(d, par_sel), "R4 parity bit",
                        int'(mon_line), int'(exp_par(d, par_sel)));
                end
                for (int s = 0; s < (two_stop ? 2 : 1); s++) begin
                    repeat (64) @(negedge clk);
                    chk(mon_line == 1'b1, "R5 stop bit", int'(mon_line), 1);
                end
                if (expq.size() == 0) begin
                    chk(1'b0, "R6 unexpected frame", int'(d), -1);
                end else begin
                    logic [8:0] e;
                    e = expq.pop_front();
                    chk(d == e, nine_bit ? "R3 nine-bit data" : "R2 R6 data order",
                        int'(d), int'(e));
                end
            end
        end
    end

    task automatic put(input logic [8:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        if (tx_irq) expq.push_back(nine_bit ? d : {1'b0, d[7:0]});
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic drain();
        wait (expq.size() == 0);
        repeat (200) @(negedge clk);
    endtask

    // watchdog
    initial begin
        repeat (180000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog R1..R11 run actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int lowrun;
        void'($urandom(32'h5EED_1234));
        repeat (5) @(negedge clk);
        chk(txd == 1'b1, "R1 reset txd", int'(txd), 1);
        chk(loop_out == 1'b1, "R1 reset loop_out", int'(loop_out), 1);
        chk(tx_irq == 1'b1, "R1 reset irq", int'(tx_irq), 1);
        rst_n = 1'b1;
        mon_en = 1'b1;
        repeat (5) @(negedge clk);

        // plain 8-bit frame, 8N1
        put(9'h0A5);
        drain();
        chk(txd == 1'b1, "R1 idle after frame", int'(txd), 1);

        // R8 hold-off with queue fill, R6 drop on full, R7 irq
        flow_en = 1'b1; cts_n = 1'b1;
        for (int i = 0; i < 4; i++) put(9'(8'h30 + i));
        chk(tx_irq == 1'b0, "R7 irq low when full", int'(tx_irq), 0);
        put(9'h0EE);
        chk(expq.size() == 4, "R6 fifth write dropped", expq.size(), 4);
        repeat (400) @(negedge clk);
        chk(txd == 1'b1 && expq.size() == 4, "R8 cts holds frames", int'(txd), 1);
        cts_n = 1'b0;
        wait (expq.size() == 3);
        @(negedge clk);
        chk(tx_irq == 1'b1, "R7 irq high after launch", int'(tx_irq), 1);
        drain();

        // R9 frame in flight completes, next one held
        put(9'h05A);
        put(9'h0C3);
        wait (txd == 1'b0);
        repeat (100) @(negedge clk);
        cts_n = 1'b1;
        repeat (1500) @(negedge clk);
        chk(expq.size() == 1, "R9 started frame completes, next held", expq.size(), 1);
        chk(txd == 1'b1, "R9 line idle while held", int'(txd), 1);
        cts_n = 1'b0;
        drain();

        // R8 flow control off: cts ignored
        flow_en = 1'b0; cts_n = 1'b1;
        put(9'h081);
        repeat (1000) @(negedge clk);
        chk(expq.size() == 0, "R8 cts ignored without flow_en", expq.size(), 0);
        cts_n = 1'b0;
        drain();

        // R4 parity on 8-bit, R3 parity ignored on 9-bit
        par_sel = 2'b01; put(9'h007); drain();
        par_sel = 2'b10; put(9'h007); drain();
        nine_bit = 1'b1; par_sel = 2'b01; put(9'h1F0); drain();
        nine_bit = 1'b0; par_sel = 2'b00;

        // R10 break length, then stop high
        mon_en = 1'b0;
        @(negedge clk); break_req = 1'b1;
        @(negedge clk); break_req = 1'b0;
        wait (txd == 1'b0);
        lowrun = 0;
        while (txd == 1'b0) begin @(negedge clk); lowrun++; end
        chk(lowrun >= 829 && lowrun <= 833, "R10 break length", lowrun, 832);
        repeat (60) @(negedge clk);
        chk(txd == 1'b1, "R10 stop after break", int'(txd), 1);
        repeat (100) @(negedge clk);

        // R10 break before data queued in the same cycle
        @(negedge clk);
        break_req = 1'b1; wr_en = 1'b1; wr_data = 9'h03C;
        expq.push_back(9'h03C);
        @(negedge clk);
        break_req = 1'b0; wr_en = 1'b0;
        wait (txd == 1'b0);
        lowrun = 0;
        while (txd == 1'b0) begin @(negedge clk); lowrun++; end
        chk(lowrun > 700, "R10 break has priority", lowrun, 832);
        repeat (10) @(negedge clk);
        mon_en = 1'b1;
        drain();

        // random batches: settings, loopback and write gaps
        for (int b = 0; b < 6; b++) begin
            nine_bit = 1'($urandom_range(0, 1));
            par_sel  = 2'($urandom_range(0, 3));
            two_stop = 1'($urandom_range(0, 1));
            loop_en  = 1'($urandom_range(0, 1));
            if (b == 0) loop_en = 1'b1;
            repeat (5) @(negedge clk);
            for (int k = 0; k < 7; k++) begin
                put(9'($urandom_range(0, 511)));
                repeat ($urandom_range(0, 700)) @(negedge clk);
            end
            drain();
        end
        loop_en = 1'b0;
        repeat (5) @(negedge clk);

        chk(loop_bad == 0, "R11 loopback line separation", loop_bad, 0);
        chk(expq.size() == 0, "R6 all frames seen", expq.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule